// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank

This block is a bank of 32 general-purpose lines behind a 32-bit register port. Each line has a direction bit, an output data bit and a sampled input bit. Any line set as an input can raise an event on a rising edge, a falling edge, a low level or a high level. Each of the four conditions is chosen per line by its own register. Every event lands in two separate status registers. Each status register has its own enable register and drives its own interrupt output, so two processors can serve the same pins independently.

Software clears status by writing ones. A line held at an enabled level reasserts its bit on the next cycle, so a level source cannot be lost by a clear. Enable, wakeup-enable and output-data registers also have set and clear alias addresses, which give single-write atomic bit updates. The bus carries byte enables. A partial write to an ordinary register merges into the stored value. A partial write to a status or alias address acts only on the bits in the enabled lanes.

A wakeup request is raised on events from lines marked for wakeup, but only while the configuration allows it. A bit in the configuration register starts a soft reset. Two debounce registers are kept for software and have no effect on detection.

Top module: `gpio_bank_dual`

## Requirements
- R1: After reset, reads return: output enable 0xFFFFFFFF, control 0x2, revision equal to the REV parameter (default 0x25) at 0x00, system status 0x1 at 0x14. Every other register reads 0, including data out.
- R2: Read/write registers are at these offsets: 0x10 config, 0x18 and 0x28 status A and B, 0x1C and 0x2C enable A and B, 0x20 wakeup enable, 0x30 control, 0x34 output enable, 0x3C data out, 0x40 low-level detect, 0x44 high-level detect, 0x48 rising detect, 0x4C falling detect, 0x50 debounce enable, 0x54 debounce time (8 bits). Writes to 0x00, 0x14 and 0x38 are ignored. Unmapped addresses read 0.
- R3: pin_out always equals data out and pin_oe_n always equals output enable. An output-enable bit of 1 makes the line an input. A line whose bit is 0 never produces an event. Offset 0x38 reads the pins as sampled on the previous clock edge.
- R4: A line produces an event in a cycle if it is an input and one of these holds: rising-detect set and the pin went 0 to 1 against the previous sample; falling-detect set and the pin went 1 to 0; high-detect set and the pin is 1; low-detect set and the pin is 0. Each event sets the line's bit in both status registers at the next clock edge.
- R5: irq_a is high exactly while (status A AND enable A) is nonzero. irq_b is high exactly while (status B AND enable B) is nonzero.
- R6: Writing a status register clears the bits written as 1. An event in the same cycle wins, so a line still at an enabled active level stays set.
- R7: Alias offsets: 0x60/0x64 clear/set enable A, 0x70/0x74 clear/set enable B, 0x80/0x84 clear/set wakeup enable, 0x90/0x94 clear/set data out. A set alias ORs the written ones in. A clear alias removes them. Each alias reads back its underlying register.
- R8: bus_be[k] enables data byte k (bits 8k+7:8k). Ordinary registers keep the bytes not enabled. At status and alias addresses, bytes not enabled count as zero.
- R9: Config keeps bits 0, 2, 3 and 4 (mask 0x1D). Control keeps 3 bits. A config write with bit 1 set returns every register to its R1 value, except data out, which is kept, and config, which takes the written value masked with 0x1D. Status is cleared even if an event occurs in the same cycle.
- R10: wake_req is high in the cycle after one in which an event occurs on a line whose wakeup-enable bit is 1, provided config bit 2 is 1 and config bits 4:3 are nonzero at that time. Otherwise it is low.
- R11: The debounce enable and debounce time registers store and read back their values and have no effect on event detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data, already in its byte lanes |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Line input levels |
| pin_out | output | 32 | Line output levels |
| pin_oe_n | output | 32 | Per-line direction, 1 = input |
| irq_a | output | 1 | Interrupt from status A and enable A |
| irq_b | output | 1 | Interrupt from status B and enable B |
| wake_req | output | 1 | Wakeup request |

## Verification
A wrong bit in a stored register appears on bus_rdata as soon as that register is addressed. For the output data and direction registers it also appears at once on pin_out or pin_oe_n. A wrong edge sample or detect term gives a status bit that is set or missing one cycle after the pin change. That error reaches irq_a or irq_b in the same cycle whenever the line is enabled. The reference model is stepped at every clock edge and all outputs are compared at every edge. Any divergence is therefore reported in the cycle it first becomes visible, not at a later read.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef logic [7:0] addr_t;

    localparam addr_t A_REV   = 8'h00;
    localparam addr_t A_SCFG  = 8'h10;
    localparam addr_t A_SSTAT = 8'h14;
    localparam addr_t A_ST1   = 8'h18;
    localparam addr_t A_EN1   = 8'h1C;
    localparam addr_t A_WKEN  = 8'h20;
    localparam addr_t A_ST2   = 8'h28;
    localparam addr_t A_EN2   = 8'h2C;
    localparam addr_t A_CTL   = 8'h30;
    localparam addr_t A_OE    = 8'h34;
    localparam addr_t A_DIN   = 8'h38;
    localparam addr_t A_DOUT  = 8'h3C;
    localparam addr_t A_LO    = 8'h40;
    localparam addr_t A_HI    = 8'h44;
    localparam addr_t A_RISE  = 8'h48;
    localparam addr_t A_FALL  = 8'h4C;
    localparam addr_t A_DBEN  = 8'h50;
    localparam addr_t A_DBT   = 8'h54;
    localparam addr_t A_EN1_C = 8'h60;
    localparam addr_t A_EN1_S = 8'h64;
    localparam addr_t A_EN2_C = 8'h70;
    localparam addr_t A_EN2_S = 8'h74;
    localparam addr_t A_WK_C  = 8'h80;
    localparam addr_t A_WK_S  = 8'h84;
    localparam addr_t A_DO_C  = 8'h90;
    localparam addr_t A_DO_S  = 8'h94;

    localparam logic [7:0] SCFG_KEEP = 8'h1D;
    localparam int         SCFG_SRST = 1;
    localparam int         SCFG_WKEN = 2;
    localparam logic [2:0] CTL_INIT  = 3'd2;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
    } detect_cfg_t;

    typedef struct packed {
        logic [DW-1:0] oe;
        logic [DW-1:0] dout;
        logic [DW-1:0] en1;
        logic [DW-1:0] en2;
        logic [DW-1:0] wken;
        logic [DW-1:0] st1;
        logic [DW-1:0] st2;
        logic [DW-1:0] dben;
        logic [7:0]    dbt;
        logic [7:0]    scfg;
        logic [2:0]    ctl;
        detect_cfg_t   det;
    } bank_regs_t;

    function automatic logic [DW-1:0] lane_mask(input logic [NB-1:0] be);
        logic [DW-1:0] m;
        for (int k = 0; k < NB; k++) m[8*k +: 8] = {8{be[k]}};
        return m;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] cur,
                                            input logic [DW-1:0] wd,
                                            input logic [DW-1:0] bm);
        return (cur & ~bm) | (wd & bm);
    endfunction

    function automatic bank_regs_t regs_reset(input logic [DW-1:0] keep_dout);
        bank_regs_t v;
        v      = '0;
        v.oe   = '1;
        v.ctl  = CTL_INIT;
        v.dout = keep_dout;
        return v;
    endfunction

endpackage

// File: rtl/gpb_detect.sv
module gpb_detect
    import gpb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pin_i,
    input  logic [DW-1:0] oe_i,
    input  detect_cfg_t   det_i,
    output logic [DW-1:0] ev_o,
    output logic [DW-1:0] din_o
);
    logic [DW-1:0] in_q;

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= pin_i;
    end

    for (genvar i = 0; i < DW; i++) begin : g_line
        logic rise_hit, fall_hit, lvl_hit;
        assign rise_hit = det_i.rise[i] &  pin_i[i] & ~in_q[i];
        assign fall_hit = det_i.fall[i] & ~pin_i[i] &  in_q[i];
        assign lvl_hit  = (det_i.hi[i] & pin_i[i]) | (det_i.lo[i] & ~pin_i[i]);
        assign ev_o[i]  = oe_i[i] & (rise_hit | fall_hit | lvl_hit);
    end

    assign din_o = in_q;

    AST_DIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> din_o == $past(pin_i)); // R3

endmodule

// File: rtl/gpb_wake.sv
module gpb_wake
    import gpb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ev_i,
    input  logic [DW-1:0] wken_i,
    input  logic [7:0]    scfg_i,
    output logic          wake_o
);
    logic allowed;
    assign allowed = scfg_i[SCFG_WKEN] && (scfg_i[4:3] != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) wake_o <= 1'b0;
        else     wake_o <= allowed && (|(ev_i & wken_i));
    end

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ($past(scfg_i[SCFG_WKEN]) && $past(scfg_i[4:3]) != 2'b00)); // R10
    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(|(ev_i & wken_i))); // R10

endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  addr_t         addr_i,
    input  logic [NB-1:0] be_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] ev_i,
    output bank_regs_t    regs_o
);
    bank_regs_t    r;
    logic [DW-1:0] bm, raw, clr1, clr2, scfg_m, ctl_m, dbt_m;
    logic          soft_w;

    always_comb begin
        bm     = lane_mask(be_i);
        raw    = wdata_i & bm;
        clr1   = (we_i && addr_i == A_ST1) ? raw : '0;
        clr2   = (we_i && addr_i == A_ST2) ? raw : '0;
        scfg_m = merge({{(DW-8){1'b0}}, r.scfg}, wdata_i, bm);
        ctl_m  = merge({{(DW-3){1'b0}}, r.ctl}, wdata_i, bm);
        dbt_m  = merge({{(DW-8){1'b0}}, r.dbt}, wdata_i, bm);
        soft_w = we_i && addr_i == A_SCFG && raw[SCFG_SRST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= regs_reset('0);
        end else begin
            r.st1 <= (r.st1 & ~clr1) | ev_i;
            r.st2 <= (r.st2 & ~clr2) | ev_i;
            if (soft_w) begin
                r      <= regs_reset(r.dout);
                r.scfg <= scfg_m[7:0] & SCFG_KEEP;
            end else if (we_i) begin
                case (addr_i)
                    A_SCFG:  r.scfg     <= scfg_m[7:0] & SCFG_KEEP;
                    A_EN1:   r.en1      <= merge(r.en1, wdata_i, bm);
                    A_EN2:   r.en2      <= merge(r.en2, wdata_i, bm);
                    A_WKEN:  r.wken     <= merge(r.wken, wdata_i, bm);
                    A_CTL:   r.ctl      <= ctl_m[2:0];
                    A_OE:    r.oe       <= merge(r.oe, wdata_i, bm);
                    A_DOUT:  r.dout     <= merge(r.dout, wdata_i, bm);
                    A_LO:    r.det.lo   <= merge(r.det.lo, wdata_i, bm);
                    A_HI:    r.det.hi   <= merge(r.det.hi, wdata_i, bm);
                    A_RISE:  r.det.rise <= merge(r.det.rise, wdata_i, bm);
                    A_FALL:  r.det.fall <= merge(r.det.fall, wdata_i, bm);
                    A_DBEN:  r.dben     <= merge(r.dben, wdata_i, bm);
                    A_DBT:   r.dbt      <= dbt_m[7:0];
                    A_EN1_C: r.en1      <= r.en1 & ~raw;
                    A_EN1_S: r.en1      <= r.en1 | raw;
                    A_EN2_C: r.en2      <= r.en2 & ~raw;
                    A_EN2_S: r.en2      <= r.en2 | raw;
                    A_WK_C:  r.wken     <= r.wken & ~raw;
                    A_WK_S:  r.wken     <= r.wken | raw;
                    A_DO_C:  r.dout     <= r.dout & ~raw;
                    A_DO_S:  r.dout     <= r.dout | raw;
                    default: ;
                endcase
            end
        end
    end

    assign regs_o = r;

    AST_EVENT_BOTH: assert property (@(posedge clk) disable iff (rst)
        (ev_i != '0 && !soft_w) |=> (((r.st1 & $past(ev_i)) == $past(ev_i)) && ((r.st2 & $past(ev_i)) == $past(ev_i)))); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        ((r.st1 & ~$past(r.st1) & ~$past(ev_i)) == '0) && ((r.st2 & ~$past(r.st2) & ~$past(ev_i)) == '0)); // R4
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == A_ST1) |=> ((r.st1 & $past(raw) & ~$past(ev_i)) == '0)); // R6
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        soft_w |=> (r.en1 == '0 && r.en2 == '0 && r.oe == '1 && r.ctl == CTL_INIT && r.st1 == '0)); // R9

endmodule

// File: rtl/gpio_bank_dual.sv
module gpio_bank_dual
    import gpb_pkg::*;
#(
    parameter logic [7:0] REV = 8'h25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe_n,
    output logic        irq_a,
    output logic        irq_b,
    output logic        wake_req
);
    bank_regs_t    regs;
    logic [DW-1:0] ev, din;

    gpb_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_in),
        .oe_i  (regs.oe),
        .det_i (regs.det),
        .ev_o  (ev),
        .din_o (din)
    );

    gpb_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .be_i    (bus_be),
        .wdata_i (bus_wdata),
        .ev_i    (ev),
        .regs_o  (regs)
    );

    gpb_wake u_wake (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev),
        .wken_i (regs.wken),
        .scfg_i (regs.scfg),
        .wake_o (wake_req)
    );

    always_comb begin
        case (bus_addr)
            A_REV:                   bus_rdata = {24'b0, REV};
            A_SCFG:                  bus_rdata = {24'b0, regs.scfg};
            A_SSTAT:                 bus_rdata = 32'd1;
            A_ST1:                   bus_rdata = regs.st1;
            A_ST2:                   bus_rdata = regs.st2;
            A_EN1, A_EN1_C, A_EN1_S: bus_rdata = regs.en1;
            A_EN2, A_EN2_C, A_EN2_S: bus_rdata = regs.en2;
            A_WKEN, A_WK_C, A_WK_S:  bus_rdata = regs.wken;
            A_CTL:                   bus_rdata = {29'b0, regs.ctl};
            A_OE:                    bus_rdata = regs.oe;
            A_DIN:                   bus_rdata = din;
            A_DOUT, A_DO_C, A_DO_S:  bus_rdata = regs.dout;
            A_LO:                    bus_rdata = regs.det.lo;
            A_HI:                    bus_rdata = regs.det.hi;
            A_RISE:                  bus_rdata = regs.det.rise;
            A_FALL:                  bus_rdata = regs.det.fall;
            A_DBEN:                  bus_rdata = regs.dben;
            A_DBT:                   bus_rdata = {24'b0, regs.dbt};
            default:                 bus_rdata = '0;
        endcase
    end

    assign pin_out  = regs.dout;
    assign pin_oe_n = regs.oe;
    assign irq_a    = |(regs.st1 & regs.en1);
    assign irq_b    = |(regs.st2 & regs.en2);

    AST_OUTPUT_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ev & ~regs.oe) == '0); // R3
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (irq_a && !$past(irq_a)) |-> ($past(ev) != '0 || $past(bus_we))); // R5

endmodule

// File: tb/gpio_bank_dual_test.sv
module gpio_bank_dual_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [3:0]  be = 4'hF;
    logic [31:0] wd = '0;
    logic [31:0] pins = '0;
    logic [31:0] rdata, pout, poe;
    logic        irq_a, irq_b, wake;

    int    total = 0;
    int    bad = 0;
    string phase = "R1";

    logic [31:0] m_oe, m_dout, m_en1, m_en2, m_wk, m_st1, m_st2, m_dben;
    logic [31:0] m_lo, m_hi, m_rise, m_fall, m_dbt, m_cfg, m_ctl, m_inq;
    logic        m_wake;

    always #(CLK_P/2) clk = ~clk;

    gpio_bank_dual uut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_be(be),
        .bus_wdata(wd), .bus_rdata(rdata), .pin_in(pins), .pin_out(pout),
        .pin_oe_n(poe), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input logic [31:0] keep);
        m_oe = '1; m_dout = keep; m_en1 = '0; m_en2 = '0; m_wk = '0;
        m_st1 = '0; m_st2 = '0; m_dben = '0; m_lo = '0; m_hi = '0;
        m_rise = '0; m_fall = '0; m_dbt = '0; m_cfg = '0; m_ctl = 32'd2;
    endtask

    function automatic logic [31:0] mrd(input logic [7:0] a);
        case (a)
            8'h00: return 32'h25;
            8'h10: return m_cfg;
            8'h14: return 32'h1;
            8'h18: return m_st1;
            8'h28: return m_st2;
            8'h1C, 8'h60, 8'h64: return m_en1;
            8'h2C, 8'h70, 8'h74: return m_en2;
            8'h20, 8'h80, 8'h84: return m_wk;
            8'h30: return m_ctl;
            8'h34: return m_oe;
            8'h38: return m_inq;
            8'h3C, 8'h90, 8'h94: return m_dout;
            8'h40: return m_lo;
            8'h44: return m_hi;
            8'h48: return m_rise;
            8'h4C: return m_fall;
            8'h50: return m_dben;
            8'h54: return m_dbt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] ev, bm, raw, c1, c2, n1, n2;
        logic        nw;
        ev = m_oe & ((m_rise & pins & ~m_inq) | (m_fall & ~pins & m_inq)
                     | (m_hi & pins) | (m_lo & ~pins));
        nw = (|(ev & m_wk)) && m_cfg[2] && (m_cfg[4:3] != 2'b00);
        for (int k = 0; k < 4; k++) bm[8*k +: 8] = be[k] ? 8'hFF : 8'h00;
        raw = wd & bm;
        c1 = (we && addr == 8'h18) ? raw : 32'h0;
        c2 = (we && addr == 8'h28) ? raw : 32'h0;
        n1 = (m_st1 & ~c1) | ev;
        n2 = (m_st2 & ~c2) | ev;
        if (we) begin
            case (addr)
                8'h10: begin
                    if (raw[1]) begin
                        model_reset(m_dout);
                        n1 = '0; n2 = '0;
                    end
                    m_cfg = ((m_cfg & ~bm) | raw) & 32'h1D;
                end
                8'h1C: m_en1 = (m_en1 & ~bm) | raw;
                8'h2C: m_en2 = (m_en2 & ~bm) | raw;
                8'h20: m_wk = (m_wk & ~bm) | raw;
                8'h30: m_ctl = ((m_ctl & ~bm) | raw) & 32'h7;
                8'h34: m_oe = (m_oe & ~bm) | raw;
                8'h3C: m_dout = (m_dout & ~bm) | raw;
                8'h40: m_lo = (m_lo & ~bm) | raw;
                8'h44: m_hi = (m_hi & ~bm) | raw;
                8'h48: m_rise = (m_rise & ~bm) | raw;
                8'h4C: m_fall = (m_fall & ~bm) | raw;
                8'h50: m_dben = (m_dben & ~bm) | raw;
                8'h54: m_dbt = ((m_dbt & ~bm) | raw) & 32'hFF;
                8'h60: m_en1 = m_en1 & ~raw;
                8'h64: m_en1 = m_en1 | raw;
                8'h70: m_en2 = m_en2 & ~raw;
                8'h74: m_en2 = m_en2 | raw;
                8'h80: m_wk = m_wk & ~raw;
                8'h84: m_wk = m_wk | raw;
                8'h90: m_dout = m_dout & ~raw;
                8'h94: m_dout = m_dout | raw;
                default: ;
            endcase
        end
        m_st1 = n1; m_st2 = n2; m_wake = nw; m_inq = pins;
    endtask

    task automatic compare();
        chk(phase, rdata, mrd(addr));
        chk("R3 pin_out", pout, m_dout);
        chk("R3 pin_oe_n", poe, m_oe);
        chk("R5 irq_a", {31'b0, irq_a}, {31'b0, |(m_st1 & m_en1)});
        chk("R5 irq_b", {31'b0, irq_b}, {31'b0, |(m_st2 & m_en2)});
        chk("R10 wake_req", {31'b0, wake}, {31'b0, m_wake});
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        we = w; addr = a; be = b; wd = d;
        @(posedge clk);
        model_step();
        #2;
        compare();
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, 4'hF, d);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b0, a, 4'hF, 32'h0);
    endtask

    task automatic pin(input logic [31:0] v);
        pins = v;
        rd(8'h18);
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset('0);
        m_inq = '0; m_wake = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, literal values
        phase = "R1";
        rd(8'h34); chk("R1 oe reset", rdata, 32'hFFFF_FFFF);
        rd(8'h30); chk("R1 ctl reset", rdata, 32'h2);
        rd(8'h00); chk("R1 revision", rdata, 32'h25);
        rd(8'h14); chk("R1 sysstatus", rdata, 32'h1);
        rd(8'h3C); chk("R1 dout reset", rdata, 32'h0);
        rd(8'h18); chk("R1 status reset", rdata, 32'h0);

        // R2 map, read-only writes, unmapped
        phase = "R2";
        wr(8'h1C, 32'h1234_5678); rd(8'h1C);
        wr(8'h20, 32'h0F0F_0F0F); rd(8'h20);
        wr(8'h2C, 32'hCAFE_0001); rd(8'h2C);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00); chk("R2 revision ro", rdata, 32'h25);
        wr(8'h14, 32'h0);         rd(8'h14); chk("R2 sysstatus ro", rdata, 32'h1);
        wr(8'h38, 32'hFFFF_FFFF); rd(8'h38); chk("R2 datain ro", rdata, 32'h0);
        rd(8'h5C); chk("R2 unmapped", rdata, 32'h0);
        wr(8'h1C, 32'h0); wr(8'h2C, 32'h0); wr(8'h20, 32'h0);

        // R3 outputs and sampled inputs
        phase = "R3";
        wr(8'h3C, 32'hA5A5_0F0F);
        wr(8'h34, 32'hFFFF_0000);
        pins = 32'h1357_9BDF; rd(8'h38); rd(8'h38);
        chk("R3 datain", rdata, 32'h1357_9BDF);
        wr(8'h34, 32'hFFFF_FFFF);
        pins = 32'h0; rd(8'h38);

        // R4 edges into both status registers
        phase = "R4";
        wr(8'h48, 32'h1); wr(8'h4C, 32'h2);
        wr(8'h1C, 32'h3); wr(8'h2C, 32'h2);
        pin(32'h1); rd(8'h18); chk("R4 rise st1", rdata, 32'h1);
        rd(8'h28); chk("R4 rise st2", rdata, 32'h1);
        pin(32'h0); pin(32'h2); pin(32'h0);
        rd(8'h28); chk("R4 fall st2", rdata, 32'h3);
        // R3 output line raises nothing
        wr(8'h18, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFE);
        pin(32'h1); pin(32'h0);
        rd(8'h18); chk("R3 output line quiet", rdata, 32'h0);
        wr(8'h34, 32'hFFFF_FFFF);

        // R6 level reassertion after clear
        phase = "R6";
        wr(8'h44, 32'h100);
        pin(32'h100); rd(8'h18);
        wr(8'h18, 32'h100); rd(8'h18); chk("R6 level reasserts", rdata, 32'h100);
        wr(8'h44, 32'h0);
        wr(8'h18, 32'h100); rd(8'h18); chk("R6 w1c clears", rdata, 32'h0);
        wr(8'h40, 32'h4); pin(32'h0); wr(8'h40, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);

        // R7 aliases
        phase = "R7";
        wr(8'h64, 32'hF0); wr(8'h60, 32'h30); rd(8'h60);
        chk("R7 en1 alias", rdata, 32'hC3);
        wr(8'h74, 32'hFF00); wr(8'h70, 32'h0F00); rd(8'h74);
        wr(8'h84, 32'h11); wr(8'h80, 32'h01); rd(8'h84);
        wr(8'h94, 32'h0000_00F0); wr(8'h90, 32'hA5A5_0000); rd(8'h94);
        chk("R7 dout alias", pout, 32'h0000_0FFF);

        // R8 byte lanes
        phase = "R8";
        cyc(1'b1, 8'h1C, 4'b0010, 32'h5555_AB55); rd(8'h1C);
        chk("R8 merge", rdata, 32'h0000_ABC3);
        cyc(1'b1, 8'h64, 4'b0001, 32'hFF00_00FF); rd(8'h1C);
        cyc(1'b1, 8'h3C, 4'b1100, 32'h1234_5678); rd(8'h3C);
        pin(32'h1); pin(32'h0);
        cyc(1'b1, 8'h18, 4'b0010, 32'hFFFF_FFFF); rd(8'h18);
        cyc(1'b1, 8'h18, 4'b0001, 32'hFFFF_FFFF); rd(8'h18);

        // R11 debounce storage only
        phase = "R11";
        wr(8'h50, 32'hFFFF_FFFF); wr(8'h54, 32'h1234); rd(8'h54);
        chk("R11 dbt width", rdata, 32'h34);
        pin(32'h1); pin(32'h0); rd(8'h18);

        // R10 wakeup gating
        phase = "R10";
        wr(8'h20, 32'h1);
        wr(8'h10, 32'h04); pin(32'h1); pin(32'h0);
        wr(8'h10, 32'h18); pin(32'h1); pin(32'h0);
        wr(8'h10, 32'h0C);
        pins = 32'h1; @(posedge clk); model_step(); #2; compare();
        chk("R10 wake asserted", {31'b0, wake}, 32'h1);
        @(negedge clk); rd(8'h10);

        // R9 config mask, control width, soft reset
        phase = "R9";
        wr(8'h30, 32'hFF); rd(8'h30); chk("R9 ctl width", rdata, 32'h7);
        wr(8'h10, 32'hE5); rd(8'h10); chk("R9 cfg mask", rdata, 32'h05);
        wr(8'h44, 32'h1); rd(8'h18);
        wr(8'h10, 32'hFF); rd(8'h10); chk("R9 cfg after soft", rdata, 32'h1D);
        rd(8'h30); chk("R9 ctl after soft", rdata, 32'h2);
        rd(8'h1C); chk("R9 en1 after soft", rdata, 32'h0);
        rd(8'h3C); rd(8'h44); rd(8'h18);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule